// File: doc/BRIEF.md
# Manchester Receive Decoder with Carrier Sense

This block turns a Manchester-coded serial stream back into NRZ data plus a receive clock. It runs from a single oversampling clock (nominally eight samples per bit) and replaces an analog phase-locked loop with digital edge timing. A counter measures the gap since the last mid-bit transition. Transitions that land in the expected mid-bit window are decoded. Earlier transitions, such as cell-boundary edges and short glitches, are ignored.

A frame begins at the first falling edge seen while the receiver is idle, and carrier sense rises at that point. When an expected mid-bit transition fails to arrive, carrier sense drops. The receive clock then keeps running for a fixed number of bit times so that a downstream controller can flush its pipeline. A loopback select takes the decoder input from the local encoder output instead of the line.

Top module: `manch_rx_cs`

## Requirements
- R1: While reset is asserted, `crs`, `rxc` and `rxd` are all low.
- R2: The first falling edge on the selected input drives `crs` high exactly 3 `clk_os` cycles after the input changes. This holds only while the receiver is idle and no tail is running. That edge is decoded as a 0 bit. Rising edges while idle are ignored.
- R3: A mid-bit rising edge decodes as 1, and a mid-bit falling edge decodes as 0, so a 1 is sent low-then-high. `rxd` changes only while `rxc` is low. `rxc` rises SPB/2 samples after each decoded edge, once per bit. `rxc` stays high for at least 2 cycles.
- R4: While carrier is up, an edge that arrives 6 to 10 samples after the previous mid-bit edge is taken as the next mid-bit edge. Any earlier edge is ignored, whether it is a cell-boundary edge or a glitch. This tolerates ±1 sample of jitter on every mid-bit edge.
- R5: If no mid-bit edge arrives within 10 samples of the previous one, `crs` falls. At the ports, `crs` goes low exactly 13 cycles after the input's last mid-bit transition, and it stays high for the whole frame before that.
- R6: After `crs` falls, `rxc` produces exactly 5 more rising edges, one per bit time, and then stays low.
- R7: While those tail clocks run, a falling edge on the input does not raise `crs` again.
- R8: With `lbk` high, the decoder uses `lb_data` and ignores `rx_in`. With `lbk` low, it uses `rx_in` and ignores `lb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_os | input | 1 | Oversampling clock, SPB samples per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Manchester line input |
| lbk | input | 1 | Loopback select, 1 = use `lb_data` |
| lb_data | input | 1 | Manchester stream from the local encoder |
| crs | output | 1 | Carrier sense |
| rxc | output | 1 | Recovered receive clock |
| rxd | output | 1 | Recovered NRZ data, valid at the rising edge of `rxc` |

## Verification
The bench plays a waveform one sample per cycle and logs `crs` just before each new sample is driven.

A transition in sample i reaches a decision register after two synchronizer stages. Carrier start is therefore checked by `crs` being low at log index i+2 and high at i+3. Carrier loss is due 10 samples after the last decoded edge, so `crs` is checked high at index m+12 and low at m+13.

Data is captured at every rising edge of `rxc` and compared with the bit list as a whole sequence, so no absolute cycle number is needed there. Tail clocks are counted the same way once `crs` is low.

// File: rtl/manch_rx_cs.sv
module manch_rx_cs #(
  parameter int SPB       = 8,
  parameter int MID_MIN   = 6,
  parameter int MID_MAX   = 10,
  parameter int TAIL_BITS = 5
) (
  input  logic clk_os,
  input  logic rst_n,
  input  logic rx_in,
  input  logic lbk,
  input  logic lb_data,
  output logic crs,
  output logic rxc,
  output logic rxd
);
  localparam int CW   = $clog2(MID_MAX + 2);
  localparam int PW   = $clog2(SPB + 1);
  localparam int TW   = $clog2(TAIL_BITS + 1);
  localparam logic [CW-1:0] GAP_LO = CW'(MID_MIN);
  localparam logic [CW-1:0] GAP_HI = CW'(MID_MAX);
  localparam logic [PW-1:0] PH_WRAP = PW'(SPB);
  localparam logic [PW-1:0] PH_HALF = PW'(SPB / 2);
  localparam logic [TW-1:0] TAIL_N  = TW'(TAIL_BITS);

  logic s_meta, s_q, s_prev;
  logic [CW-1:0] gap_q;
  logic [PW-1:0] ph_q;
  logic [TW-1:0] tail_q;

  wire line_sel = lbk ? lb_data : rx_in;
  wire edge_w   = s_q ^ s_prev;
  wire tail_on  = (tail_q != '0);
  wire start_w  = ~crs & ~tail_on & edge_w & ~s_q;
  wire mid_w    = crs & edge_w & (gap_q >= GAP_LO) & (gap_q <= GAP_HI);
  wire lost_w   = crs & ~mid_w & (gap_q >= GAP_HI);
  wire bit_w    = start_w | mid_w;
  wire run_w    = crs | tail_on;

  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_q    <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= line_sel;
      s_q    <= s_meta;
      s_prev <= s_q;
    end
  end

  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n)       crs <= 1'b0;
    else if (start_w) crs <= 1'b1;
    else if (lost_w)  crs <= 1'b0;
  end

  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n)                    gap_q <= '0;
    else if (bit_w)                gap_q <= CW'(1);
    else if (crs && gap_q < GAP_HI) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n)                                tail_q <= '0;
    else if (lost_w)                           tail_q <= TAIL_N;
    else if (!crs && tail_on && ph_q == PH_HALF) tail_q <= tail_q - 1'b1;
  end

  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      rxc  <= 1'b0;
      rxd  <= 1'b0;
    end else if (bit_w) begin
      ph_q <= PW'(1);
      rxc  <= 1'b0;
      rxd  <= s_q;
    end else begin
      ph_q <= (ph_q >= PH_WRAP) ? PW'(1) : ph_q + 1'b1;
      if (ph_q >= PH_WRAP)                rxc <= 1'b0;
      else if (ph_q == PH_HALF && run_w)  rxc <= 1'b1;
    end
  end
endmodule

// File: rtl/manch_rx_cs_chk.sv
module manch_rx_cs_chk #(
  parameter int TAIL_BITS = 5,
  parameter int TW = 3
) (
  input logic          clk_os,
  input logic          rst_n,
  input logic          crs,
  input logic          rxc,
  input logic          rxd,
  input logic [TW-1:0] tail_q
);
  always @(posedge clk_os)
    if (!rst_n) p_reset_quiet_r1: assert (!crs && !rxc && !rxd);

  p_start_only_idle_r2: assert property (@(posedge clk_os) disable iff (!rst_n)
    $rose(crs) |-> $past(tail_q) == '0);

  p_rxd_moves_low_r3: assert property (@(posedge clk_os) disable iff (!rst_n)
    !$stable(rxd) |-> !rxc);

  p_rxc_min_high_r3: assert property (@(posedge clk_os) disable iff (!rst_n)
    $rose(rxc) |=> rxc);

  p_tail_loaded_r6: assert property (@(posedge clk_os) disable iff (!rst_n)
    $fell(crs) |-> tail_q == TW'(TAIL_BITS));

  p_rxc_needs_run_r6: assert property (@(posedge clk_os) disable iff (!rst_n)
    $rose(rxc) |-> ($past(crs) || $past(tail_q) != '0));

  p_no_restart_tail_r7: assert property (@(posedge clk_os) disable iff (!rst_n)
    (!crs && tail_q != '0) |=> !crs);
endmodule

bind manch_rx_cs manch_rx_cs_chk #(.TAIL_BITS(TAIL_BITS), .TW(TW)) u_chk (
  .clk_os(clk_os), .rst_n(rst_n), .crs(crs), .rxc(rxc), .rxd(rxd), .tail_q(tail_q)
);

// File: tb/test_manch_rx_cs.sv
module test_manch_rx_cs;
  localparam int TAIL = 5;

  logic clk_os = 1'b0;
  logic rst_n  = 1'b1;
  logic rx_in  = 1'b0;
  logic lbk    = 1'b0;
  logic lb_data = 1'b0;
  wire  crs, rxc, rxd;

  manch_rx_cs i_manch_rx_cs (
    .clk_os(clk_os), .rst_n(rst_n), .rx_in(rx_in), .lbk(lbk),
    .lb_data(lb_data), .crs(crs), .rxc(rxc), .rxd(rxd)
  );

  always #4 clk_os = ~clk_os;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic wv[0:1023];
  logic crs_log[0:1023];
  int   wlen;
  logic bits[0:63];
  int   mid_at[0:63];
  int   nb;

  logic cap[0:127];
  int   ncap = 0;
  int   ntail = 0;
  logic rxc_seen = 1'b0;

  always @(negedge clk_os) begin
    if (rxc && !rxc_seen) begin
      if (crs) begin
        if (ncap < 128) cap[ncap] = rxd;
        ncap++;
      end else ntail++;
    end
    rxc_seen = rxc;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input int n, input bit jit, input int glitch_k, input bit poke);
    int w = 0;
    nb = n;
    for (int i = 0; i < 12; i++) begin wv[w] = 1'b0; w++; end
    for (int k = 0; k < n; k++) begin
      int j = jit ? int'($urandom_range(2, 0)) - 1 : 0;
      for (int s = 0; s < 4 + j; s++) begin wv[w] = ~bits[k]; w++; end
      mid_at[k] = w;
      for (int s = 0; s < 4 - j; s++) begin wv[w] = bits[k]; w++; end
      if (k == glitch_k) wv[mid_at[k] + 1] = ~bits[k];
    end
    for (int i = 0; i < 80; i++) begin wv[w] = 1'b0; w++; end
    if (poke) begin
      wv[mid_at[n-1] + 20] = 1'b1;
      wv[mid_at[n-1] + 21] = 1'b1;
      wv[mid_at[n-1] + 22] = 1'b1;
    end
    wlen = w;
  endtask

  task automatic play(input bit via_lb);
    ncap = 0;
    ntail = 0;
    for (int i = 0; i < wlen; i++) begin
      @(negedge clk_os);
      crs_log[i] = crs;
      lbk = via_lb;
      if (via_lb) begin lb_data = wv[i]; rx_in = 1'($urandom); end
      else        begin rx_in = wv[i]; lb_data = 1'($urandom); end
    end
    @(negedge clk_os);
    rx_in = 1'b0;
    lb_data = 1'b0;
  endtask

  task automatic verify(input string tag, input bit poke);
    int f = mid_at[0];
    int m = mid_at[nb-1];
    int bad = 0;
    int err = 0;
    chk({tag, " R2 crs low before start"}, int'(crs_log[f+2]), 0);
    chk({tag, " R2 crs rises 3 cycles after first fall"}, int'(crs_log[f+3]), 1);
    for (int i = f + 3; i <= m + 12; i++) if (crs_log[i] !== 1'b1) bad++;
    chk({tag, " R5 crs held through frame"}, bad, 0);
    chk({tag, " R5 crs drops 13 cycles after last mid edge"}, int'(crs_log[m+13]), 0);
    chk({tag, " R3 decoded bit count"}, ncap, nb);
    for (int k = 0; k < nb && k < 128; k++) if (cap[k] !== bits[k]) err++;
    chk({tag, " R3 decoded bit values"}, err, 0);
    chk({tag, " R6 tail rxc rises"}, ntail, TAIL);
    chk({tag, " R6 rxc low after tail"}, int'(rxc), 0);
    if (poke) begin
      bad = 0;
      for (int i = m + 13; i < wlen; i++) if (crs_log[i] !== 1'b0) bad++;
      chk({tag, " R7 no restart during tail"}, bad, 0);
    end
  endtask

  task automatic fill(input int n, input int pattern);
    bits[0] = 1'b0;
    for (int k = 1; k < n; k++)
      case (pattern)
        0: bits[k] = k[0];
        1: bits[k] = 1'b0;
        2: bits[k] = 1'b1;
        default: bits[k] = 1'($urandom);
      endcase
  endtask

  initial begin
    int hits;
    void'($urandom(32'd2718));
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk_os);
    chk("R1 crs in reset", int'(crs), 0);
    chk("R1 rxc in reset", int'(rxc), 0);
    chk("R1 rxd in reset", int'(rxd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_os);

    fill(16, 0); build(16, 0, -1, 0); play(0); verify("alt", 0);
    fill(12, 1); build(12, 0, -1, 0); play(0); verify("zeros R4 boundary", 0);
    fill(12, 2); build(12, 0, -1, 0); play(0); verify("ones R4 boundary", 0);
    fill(24, 3); build(24, 1, 5, 0); play(0); verify("R4 jitter+glitch", 0);
    fill(20, 3); build(20, 1, -1, 0); play(1); verify("R8 loopback", 0);
    fill(10, 3); build(10, 0, -1, 1); play(0); verify("R7 tail poke", 1);

    hits = 0;
    lbk = 1'b1; lb_data = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_os);
      if (crs || rxc) hits++;
      rx_in = 1'($urandom);
    end
    chk("R8 rx_in ignored in loopback", hits, 0);
    rx_in = 1'b0;
    @(negedge clk_os);
    lbk = 1'b0;
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_os);
      if (crs || rxc) hits++;
      lb_data = 1'($urandom);
    end
    chk("R8 lb_data ignored without loopback", hits, 0);
    lb_data = 1'b0;

    for (int r = 0; r < 8; r++) begin
      int n = int'($urandom_range(40, 8));
      bit lb = 1'($urandom);
      fill(n, 3);
      build(n, 1'b1, (r % 2 == 0) ? int'($urandom_range(n - 2, 1)) : -1, 0);
      play(lb);
      verify("R4 random", 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule